// File: doc/BRIEF.md
# Data-Phase Bit Timing Engine

This block times the fast data phase of a CAN-style serial bus. A prescaler turns the controller clock into time quanta. A segment sequencer then walks each bit through three segments: a one-quantum sync segment, a first timing segment that covers propagation plus phase 1, and a second timing segment that is phase 2. The block raises a strobe at the sample point and another at the end of the bit. A frame engine samples the bus on the sample strobe, so its decision for the next bit is ready on the clock edge right after the sample point.

The segment and prescaler values come from a single configuration word. That word can be written only while both the initialization and configuration-enable controls are high. While initialization is high the engine is held at the start of a sync segment. An edge-detect input carries pulses that mark recessive-to-dominant transitions. On such an edge the sequencer resynchronizes: it lengthens the first segment or shortens the second, by at most the programmed jump width plus one quantum. Nothing in the block streams data, so every pin is a plain control or status signal and there is no back-pressure.

Top module: `dbt_engine`

## Requirements
- R1: A write with `cfg_wr`, `cfg_init` and `cfg_unlock` all high stores the word. `cfg_rdata` then shows the stored fields at fixed positions and zero in every other bit. The positions are: jump width in bits 3:0, second segment in bits 7:4, first segment in bits 12:8, prescaler in bits 20:16, and delay-compensation enable in bit 23.
- R2: A write made while `cfg_init` or `cfg_unlock` is low has no effect. `cfg_rdata` stays as it was and the bit timing does not change.
- R3: While running, `tq_tick` pulses for one clock once every prescaler+1 clocks, which gives a range of 1 to 32 clocks.
- R4: Without resynchronization, one bit lasts first segment + second segment + 3 quanta. `bit_end_stb` is high in the last clock of the bit.
- R5: `sample_stb` is high in the last clock of the first segment, which is first segment + 2 quanta after the bit starts.
- R6: While `cfg_init` is high, no strobe is produced. The first clock with `cfg_init` low is the first clock of a sync segment.
- R7: An edge that falls in the first segment lengthens that segment by jump width + 1 quanta.
- R8: An edge that falls in the second segment shortens it by jump width + 1 quanta. The segment is never shortened below the quanta it has already used, so in that case the bit ends with the current quantum.
- R9: An edge in the sync segment, or in the bit-end clock, has no effect. Only the first qualifying edge in a bit acts.
- R10: An edge in the same clock as `sample_stb` counts as an edge at the start of the second segment.
- R11: After reset the stored word is zero and all strobes are low.
- R12: `tdc_en` follows the stored delay-compensation enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| cfg_init | input | 1 | Initialization control; holds the engine idle |
| cfg_unlock | input | 1 | Configuration-enable control |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Stored configuration word |
| rx_edge | input | 1 | Recessive-to-dominant edge pulse |
| tq_tick | output | 1 | Last clock of each time quantum |
| sample_stb | output | 1 | Sample-point strobe |
| bit_end_stb | output | 1 | Bit-boundary strobe |
| tdc_en | output | 1 | Stored delay-compensation enable |

## Verification
The two functions that can meet in one clock are segment advance and edge resynchronization. An edge can arrive in the same clock as the sample strobe, or in the same clock as the bit-end strobe. The bench places edge pulses on exactly the sample clock and on exactly the bit-end clock. It judges the result by the length of the bit in progress and of the following bit. The first case must give a shortened second segment. The second case must leave the next bit at its nominal length. A behavioural model that counts clocks and quanta also predicts every strobe in every clock.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int SJW_W = 4;
  localparam int TS2_W = 4;
  localparam int TS1_W = 5;
  localparam int BRP_W = 5;
  localparam int SJW_LSB = 0;
  localparam int TS2_LSB = 4;
  localparam int TS1_LSB = 8;
  localparam int BRP_LSB = 16;
  localparam int TDC_BIT = 23;
  // quantum index wide enough for an extended first segment
  localparam int Q_W = TS1_W + 2;

  typedef struct packed {
    logic             tdc;
    logic [BRP_W-1:0] brp;
    logic [TS1_W-1:0] ts1;
    logic [TS2_W-1:0] ts2;
    logic [SJW_W-1:0] sjw;
  } dbt_cfg_t;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } dbt_phase_e;

  function automatic logic [31:0] field_mask(input int lsb, input int w);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < w; i++) m[lsb+i] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] WR_MASK =
    field_mask(SJW_LSB, SJW_W) | field_mask(TS2_LSB, TS2_W) |
    field_mask(TS1_LSB, TS1_W) | field_mask(BRP_LSB, BRP_W) |
    field_mask(TDC_BIT, 1);
endpackage

// File: rtl/dbt_cfg_reg.sv
module dbt_cfg_reg
  import dbt_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             init,
  input  logic             unlock,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output dbt_cfg_t         cfg
);
  localparam logic [REG_W-1:0] MASK = REG_W'(WR_MASK);

  logic [REG_W-1:0] word_q;
  logic             wr_ok;

  assign wr_ok = wr && init && unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_ok) word_q <= wdata & MASK;
  end

  assign rdata   = word_q;
  assign cfg.sjw = word_q[SJW_LSB +: SJW_W];
  assign cfg.ts2 = word_q[TS2_LSB +: TS2_W];
  assign cfg.ts1 = word_q[TS1_LSB +: TS1_W];
  assign cfg.brp = word_q[BRP_LSB +: BRP_W];
  assign cfg.tdc = word_q[TDC_BIT];

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && init && unlock) |=> $stable(rdata));
endmodule

// File: rtl/dbt_prescaler.sv
module dbt_prescaler #(
  parameter int BRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [BRP_W-1:0] brp,
  output logic             tick
);
  logic [BRP_W-1:0] pc;

  assign tick = run && (pc == brp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc <= '0;
    else if (!run || tick) pc <= '0;
    else                 pc <= pc + 1'b1;
  end

  // R3
  tq_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> pc == $past(pc) + 1'b1);
endmodule

// File: rtl/dbt_seg_seq.sv
module dbt_seg_seq
  import dbt_pkg::*;
#(
  parameter int TS1_W = dbt_pkg::TS1_W,
  parameter int TS2_W = dbt_pkg::TS2_W,
  parameter int SJW_W = dbt_pkg::SJW_W,
  parameter int Q_W   = dbt_pkg::Q_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             rx_edge,
  input  logic [TS1_W-1:0] ts1,
  input  logic [TS2_W-1:0] ts2,
  input  logic [SJW_W-1:0] sjw,
  output logic             sample_stb,
  output logic             bit_end_stb
);
  dbt_phase_e       phase, nxt_phase;
  logic [Q_W-1:0]   q, nxt_q, lim1, jump, ext1, ts2_q;
  logic [TS2_W-1:0] lim2, short2;
  logic             used, edge_act, room;

  assign jump   = Q_W'(sjw) + Q_W'(1);
  assign ext1   = Q_W'(ts1) + jump;
  assign ts2_q  = Q_W'(ts2);
  assign sample_stb  = tick && (phase == PH_SEG1) && (q == lim1);
  assign bit_end_stb = tick && (phase == PH_SEG2) && (q == Q_W'(lim2));

  always_comb begin
    nxt_phase = phase;
    nxt_q     = q;
    if (tick) begin
      case (phase)
        PH_SYNC: begin nxt_phase = PH_SEG1; nxt_q = '0; end
        PH_SEG1: if (q == lim1) begin nxt_phase = PH_SEG2; nxt_q = '0; end
                 else nxt_q = q + 1'b1;
        PH_SEG2: if (q == Q_W'(lim2)) begin nxt_phase = PH_SYNC; nxt_q = '0; end
                 else nxt_q = q + 1'b1;
        default: begin nxt_phase = PH_SYNC; nxt_q = '0; end
      endcase
    end
  end

  // an edge is judged by the segment the next clock belongs to
  assign edge_act = rx_edge && !used && (phase != PH_SYNC) && (nxt_phase != PH_SYNC);
  assign room     = ts2_q >= (nxt_q + jump);
  assign short2   = room ? TS2_W'(ts2_q - jump) : TS2_W'(nxt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_SYNC;
      q     <= '0;
      lim1  <= '0;
      lim2  <= '0;
      used  <= 1'b0;
    end else if (!run) begin
      phase <= PH_SYNC;
      q     <= '0;
      lim1  <= Q_W'(ts1);
      lim2  <= ts2;
      used  <= 1'b0;
    end else begin
      phase <= nxt_phase;
      q     <= nxt_q;
      if (phase == PH_SYNC) begin
        lim1 <= Q_W'(ts1);
        lim2 <= ts2;
        used <= 1'b0;
      end else if (edge_act) begin
        used <= 1'b1;
        if (nxt_phase == PH_SEG1) lim1 <= ext1;
        else                      lim2 <= short2;
      end
    end
  end

  // R4
  end_to_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_stb |=> (phase == PH_SYNC) && (q == '0));

  // R9
  one_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used && run && (phase != PH_SYNC) |=> $stable(lim1) && $stable(lim2));

  // R10
  sample_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && sample_stb && rx_edge && !used |=> (phase == PH_SEG2) && used);
endmodule

// File: rtl/dbt_engine.sv
module dbt_engine
  import dbt_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_init,
  input  logic             cfg_unlock,
  input  logic             cfg_wr,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  input  logic             rx_edge,
  output logic             tq_tick,
  output logic             sample_stb,
  output logic             bit_end_stb,
  output logic             tdc_en
);
  dbt_cfg_t cfg;
  logic     run;

  assign run    = !cfg_init;
  assign tdc_en = cfg.tdc;

  dbt_cfg_reg #(.REG_W(REG_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .init(cfg_init),
    .unlock(cfg_unlock), .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  dbt_prescaler #(.BRP_W(BRP_W)) i_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .brp(cfg.brp), .tick(tq_tick)
  );

  dbt_seg_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W), .Q_W(Q_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tq_tick), .rx_edge(rx_edge),
    .ts1(cfg.ts1), .ts2(cfg.ts2), .sjw(cfg.sjw),
    .sample_stb(sample_stb), .bit_end_stb(bit_end_stb)
  );

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_init |-> !tq_tick && !sample_stb && !bit_end_stb);
endmodule

// File: tb/test_dbt_engine.sv
module test_dbt_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_init = 1'b1, cfg_unlock = 1'b0, cfg_wr = 1'b0, rx_edge = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic tq_tick, sample_stb, bit_end_stb, tdc_en;

  always #2 clk = ~clk;

  dbt_engine i_dbt_engine (
    .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .cfg_unlock(cfg_unlock),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .rx_edge(rx_edge), .tq_tick(tq_tick), .sample_stb(sample_stb),
    .bit_end_stb(bit_end_stb), .tdc_en(tdc_en)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit [4:0] brp, input bit [4:0] ts1,
                                     input bit [3:0] ts2, input bit [3:0] sjw, input bit tdc);
    return {8'd0, tdc, 2'd0, brp, 3'd0, ts1, ts2, sjw};
  endfunction

  // behavioural model: clocks into the quantum, quanta into the bit
  int m_pc, m_qi, m_L1, m_L2, m_brp, m_ts1, m_ts2, m_sjw;
  bit m_used, m_tdc;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_qi = 0; m_L1 = 1; m_L2 = 1; m_used = 0;
      m_brp = 0; m_ts1 = 0; m_ts2 = 0; m_sjw = 0; m_tdc = 0;
    end else begin
      if (cfg_init) begin
        m_pc = 0; m_qi = 0; m_L1 = m_ts1 + 1; m_L2 = m_ts2 + 1; m_used = 0;
      end else begin
        bit tk, be;
        int nqi;
        if (m_qi == 0) begin m_L1 = m_ts1 + 1; m_L2 = m_ts2 + 1; m_used = 0; end
        tk = (m_pc == m_brp);
        be = tk && (m_qi == m_L1 + m_L2);
        if (tk) begin m_pc = 0; nqi = be ? 0 : m_qi + 1; end
        else begin m_pc = m_pc + 1; nqi = m_qi; end
        if (rx_edge && !m_used && m_qi != 0 && nqi != 0) begin
          m_used = 1;
          if (nqi <= m_L1) m_L1 = m_ts1 + m_sjw + 2;
          else m_L2 = (m_ts2 - m_sjw > nqi - m_L1) ? m_ts2 - m_sjw : nqi - m_L1;
        end
        m_qi = nqi;
      end
      if (cfg_wr && cfg_init && cfg_unlock) begin
        m_sjw = int'(cfg_wdata[3:0]);  m_ts2 = int'(cfg_wdata[7:4]);
        m_ts1 = int'(cfg_wdata[12:8]); m_brp = int'(cfg_wdata[20:16]);
        m_tdc = cfg_wdata[23];
      end
    end
  end

  // monitor: compare every clock and keep per-bit statistics
  int ncyc = 0, last_end = 0, prev_end = 0, last_smp = 0, rel_cyc = 0;
  int tcnt = 0, last_ticks = 0;
  logic prev_init = 1'b1;
  event end_ev, smp_ev;

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    ncyc++;
    if (rst_n) begin
      bit e_tick, e_smp, e_end;
      e_tick = !cfg_init && (m_pc == m_brp);
      e_smp  = e_tick && (m_qi == m_L1);
      e_end  = e_tick && (m_qi == m_L1 + m_L2);
      chk(tq_tick == e_tick, "R3 model tick", int'(tq_tick), int'(e_tick));
      chk(sample_stb == e_smp, "R5 model sample", int'(sample_stb), int'(e_smp));
      chk(bit_end_stb == e_end, "R4 model bit end", int'(bit_end_stb), int'(e_end));
      chk(cfg_rdata == mk(5'(m_brp), 5'(m_ts1), 4'(m_ts2), 4'(m_sjw), m_tdc),
          "R1 model readback", int'(cfg_rdata),
          int'(mk(5'(m_brp), 5'(m_ts1), 4'(m_ts2), 4'(m_sjw), m_tdc)));
      if (prev_init && !cfg_init) begin rel_cyc = ncyc; tcnt = 0; end
      if (tq_tick) tcnt++;
      if (sample_stb) begin last_smp = ncyc; -> smp_ev; end
      if (bit_end_stb) begin
        prev_end = last_end; last_end = ncyc; last_ticks = tcnt; tcnt = 0;
        -> end_ev;
      end
    end
    prev_init = cfg_init;
    if (ncyc > 150000 && !done) begin
      chk(0, "watchdog", ncyc, 150000);
      finish_up();
    end
  end

  task automatic wr(input logic [31:0] w, input logic init, input logic unl);
    @(posedge clk); #1;
    cfg_wdata = w; cfg_wr = 1'b1; cfg_init = init; cfg_unlock = unl;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic release_init();
    @(posedge clk); #1;
    cfg_init = 1'b0;
  endtask

  // sync on a bit end, pulse edges at clocks c1 and c2 of the next bit, then wait for a bit end
  task automatic shot(input int c1, input int c2);
    @(end_ev);
    @(posedge clk);
    if (c1 >= 0) begin
      repeat (c1) @(posedge clk);
      #1 rx_edge = 1'b1;
      @(posedge clk); #1 rx_edge = 1'b0;
      if (c2 >= 0) begin
        repeat (c2 - c1 - 1) @(posedge clk);
        #1 rx_edge = 1'b1;
        @(posedge clk); #1 rx_edge = 1'b0;
      end
    end
    @(end_ev);
  endtask

  initial begin
    logic [31:0] w1;
    int quiet;
    w1 = mk(5'd2, 5'd3, 4'd2, 4'd1, 1'b1);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cfg_rdata == 32'd0, "R11 reset word", int'(cfg_rdata), 0);
    chk(!sample_stb && !bit_end_stb && !tq_tick, "R11 strobes low", int'(bit_end_stb), 0);
    chk(!tdc_en, "R11 tdc low", int'(tdc_en), 0);

    wr(w1, 1'b1, 1'b1);
    chk(cfg_rdata == w1, "R1 gated write", int'(cfg_rdata), int'(w1));
    chk(tdc_en == 1'b1, "R12 tdc enable", int'(tdc_en), 1);
    wr(32'hFFFF_FFFF, 1'b1, 1'b0);
    chk(cfg_rdata == w1, "R2 write without unlock", int'(cfg_rdata), int'(w1));

    release_init();
    @(smp_ev);
    chk(last_smp - rel_cyc == 14, "R6 first sample after release", last_smp - rel_cyc, 14);
    @(end_ev);
    chk(last_end - rel_cyc == 23, "R6 first bit end after release", last_end - rel_cyc, 23);

    shot(-1, -1);
    chk(last_end - prev_end == 24, "R4 nominal bit", last_end - prev_end, 24);
    chk(last_smp - prev_end == 15, "R5 sample point", last_smp - prev_end, 15);
    chk(last_ticks == 8, "R3 quanta per bit", last_ticks, 8);

    shot(6, -1);
    chk(last_end - prev_end == 30, "R7 phase-1 edge lengthens", last_end - prev_end, 30);
    chk(last_smp - prev_end == 21, "R7 sample moves later", last_smp - prev_end, 21);
    shot(15, -1);
    chk(last_end - prev_end == 18, "R8 phase-2 edge shortens", last_end - prev_end, 18);
    shot(18, -1);
    chk(last_end - prev_end == 21, "R8 shortening floor", last_end - prev_end, 21);
    shot(1, -1);
    chk(last_end - prev_end == 24, "R9 sync edge ignored", last_end - prev_end, 24);
    shot(6, 16);
    chk(last_end - prev_end == 30, "R9 second edge ignored", last_end - prev_end, 30);
    shot(14, -1);
    chk(last_end - prev_end == 18, "R10 edge on sample clock", last_end - prev_end, 18);
    shot(23, -1);
    chk(last_end - prev_end == 24, "R9 edge on bit-end clock", last_end - prev_end, 24);

    wr(mk(5'd7, 5'd7, 4'd7, 4'd7, 1'b0), 1'b0, 1'b1);
    chk(cfg_rdata == w1, "R2 write without init", int'(cfg_rdata), int'(w1));
    shot(-1, -1);
    chk(last_end - prev_end == 24, "R2 timing unchanged", last_end - prev_end, 24);

    @(posedge clk); #1 cfg_init = 1'b1;
    quiet = 0;
    repeat (40) begin
      @(negedge clk);
      if (tq_tick || sample_stb || bit_end_stb) quiet++;
    end
    chk(quiet == 0, "R6 idle while init", quiet, 0);

    wr(mk(5'd0, 5'd0, 4'd0, 4'd0, 1'b0), 1'b1, 1'b1);
    chk(tdc_en == 1'b0, "R12 tdc cleared", int'(tdc_en), 0);
    release_init();
    shot(-1, -1);
    chk(last_end - prev_end == 3, "R4 shortest bit", last_end - prev_end, 3);
    chk(last_smp - prev_end == 2, "R5 shortest sample", last_smp - prev_end, 2);
    chk(last_ticks == 3, "R3 one-clock quanta", last_ticks, 3);

    wr(mk(5'd31, 5'd1, 4'd0, 4'd0, 1'b0), 1'b1, 1'b1);
    release_init();
    shot(-1, -1);
    chk(last_end - prev_end == 128, "R4 longest quantum bit", last_end - prev_end, 128);
    chk(last_ticks == 4, "R3 32-clock quanta", last_ticks, 4);

    done = 1;
    finish_up();
  end
endmodule